// File: doc/BRIEF.md
# Flow-Controlled Burst DMA Channel

This block is one DMA channel that copies a byte count from a source address to a target address. It works in bursts. Each burst reads whole 32-bit words from the read port into a 32-byte staging buffer. It then writes those words out through the write port. Both ports are valid/ready streams that carry one word per handshake.

A descriptor is loaded in a single cycle and starts the channel. The descriptor holds:
- a source address and a target address;
- a byte length and a two-bit burst-size code;
- an address-increment enable for each side;
- a flow-control enable for each side;
- an interrupt enable.

A side marked flow-controlled waits for a peripheral request before each burst. The wait happens before the reads on the source side and before the writes on the target side. Two request lines are registered on every clock. Each line carries a 4-bit channel number and is honoured only when that number equals this channel's identity.

After each burst, the length drops by the burst's byte count, min(remaining length, burst size). Each address moves by the same amount when its side increments. Otherwise the address stays fixed, which suits a FIFO-style peripheral. When the length reaches zero the channel returns to idle. At that point it raises a sticky interrupt if the interrupt enable is set.

Top module: `dma_flow_chan`

## Requirements
- R1: After reset the channel is idle: busy_o, err_o, irq_o, rd_valid_o and wr_valid_o are 0, and len_o is 0.
- R2: A pulse on ld_i while idle loads the descriptor and makes busy_o 1 on the next cycle. A pulse on ld_i while busy has no effect on the transfer in progress.
- R3: Burst-size code 1, 2 and 3 select 8, 16 and 32 bytes. A burst moves n = min(len, size) bytes as ceil(n/4) word reads, and all of them finish before the first of its ceil(n/4) word writes. The k-th write carries the word read by the k-th read.
- R4: After each burst, len_o drops by n. When it reaches 0, busy_o returns to 0.
- R5: Within a burst, word k uses address base+4k on a side whose increment bit is 1, and base otherwise. After the burst, that side's base advances by n if its increment bit is 1 and stays put otherwise.
- R6: wr_be_o is 4'b1111 except on the last word of a burst whose n mod 4 = r is non-zero. On that word it is ((1<<r)-1), so that bit i enables byte i (bits 7:0 are byte 0).
- R7: With source flow control set, no read starts in a burst until a mapped request has been seen, and this holds again for every burst.
- R8: With target flow control set, a burst's reads complete but no write starts until a mapped request has been seen.
- R9: Request line i is mapped when map_i[4i+3:4i] equals CHAN_ID. A request on an unmapped line never releases a wait, and requests raised while idle have no effect on a later transfer.
- R10: If the interrupt enable is set, irq_o rises in the cycle busy_o falls at the end of the transfer. It stays 1 until a cycle with irq_clr_i = 1.
- R11: Loading burst-size code 0 sets err_o and starts no transfer. The next load with a valid code clears err_o.
- R12: Once rd_valid_o or wr_valid_o is 1, it stays 1 with stable address, data and byte enables until the matching ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_i | input | 1 | Descriptor load and start strobe |
| ld_src_i | input | 32 | Source base address (word aligned) |
| ld_tgt_i | input | 32 | Target base address (word aligned) |
| ld_len_i | input | LEN_W | Byte length |
| ld_bsz_i | input | 2 | Burst-size code (1:8, 2:16, 3:32 bytes, 0 invalid) |
| ld_inc_src_i | input | 1 | Source address increment enable |
| ld_inc_tgt_i | input | 1 | Target address increment enable |
| ld_flow_src_i | input | 1 | Wait for a request before each burst's reads |
| ld_flow_tgt_i | input | 1 | Wait for a request before each burst's writes |
| ld_irq_en_i | input | 1 | Interrupt enable |
| dreq_i | input | NUM_REQ | Peripheral request lines |
| map_i | input | NUM_REQ*4 | Channel number per request line |
| irq_clr_i | input | 1 | Clears irq_o |
| busy_o | output | 1 | Channel running |
| err_o | output | 1 | Invalid burst code was loaded |
| irq_o | output | 1 | Sticky completion interrupt |
| len_o | output | LEN_W | Remaining byte length |
| src_addr_o | output | 32 | Current source base |
| tgt_addr_o | output | 32 | Current target base |
| rd_valid_o | output | 1 | Read word request valid |
| rd_addr_o | output | 32 | Read word address |
| rd_ready_i | input | 1 | Read accepted; rd_data_i valid in the same cycle |
| rd_data_i | input | 32 | Read word data |
| wr_valid_o | output | 1 | Write word valid |
| wr_addr_o | output | 32 | Write word address |
| wr_data_o | output | 32 | Write word data |
| wr_be_o | output | 4 | Write byte enables |
| wr_ready_i | input | 1 | Write accepted |

## Verification
The bench sweeps every length from 1 to 36 under each burst-size code. It also crosses every pairing of the increment bits, with and without back-pressure, and predicts each write word arithmetically.

The sweep targets particular faults:
- A design that advanced by the full burst size on the final short burst would leave the wrong final addresses.
- A design that mis-masked the tail would show a wrong byte enable on lengths that are not a multiple of four.
- A design that dropped a stalled word would lose data under back-pressure.

Flow control is probed with and without requests:
- Requests are withheld, placed on a line mapped elsewhere, and raised while idle. A channel that ignored the mapping or latched stale requests would start early.
- A single request pulse must release exactly one burst.

The sweep also checks that an invalid burst code and a load made while busy leave the transfer untouched.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int BUF_WORDS = 8;                       // 32-byte staging buffer
  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int BEAT_W    = IDX_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SRC,
    ST_READ,
    ST_WAIT_TGT,
    ST_WRITE
  } dma_state_e;

  typedef struct packed {
    logic [1:0] bsz;
    logic       inc_src;
    logic       inc_tgt;
    logic       flow_src;
    logic       flow_tgt;
    logic       irq_en;
  } dma_cmd_t;
endpackage

// File: rtl/dma_req_map.sv
module dma_req_map #(
  parameter int NUM_REQ = 2,
  parameter int CHAN_W  = 4,
  parameter int CHAN_ID = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        dreq_i,
  input  logic [NUM_REQ*CHAN_W-1:0] map_i,
  output logic                      hit_o
);
  logic [NUM_REQ-1:0] dreq_q;
  logic [NUM_REQ-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_q <= '0;
    else        dreq_q <= dreq_i;
  end

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_line
    assign match[k] = dreq_q[k] && (map_i[k*CHAN_W +: CHAN_W] == CHAN_W'(CHAN_ID));
  end

  assign hit_o = |match;
endmodule

// File: rtl/dma_burst_calc.sv
module dma_burst_calc
  import dmac_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic [1:0]        bsz_i,
  output logic [LEN_W-1:0]  n_o,
  output logic [BEAT_W-1:0] beats_o,
  output logic [BE_W-1:0]   last_be_o
);
  logic [LEN_W-1:0] cap;

  always_comb begin
    cap     = LEN_W'(4) << bsz_i;
    n_o     = (len_i < cap) ? len_i : cap;
    beats_o = BEAT_W'((n_o + LEN_W'(3)) >> 2);
    case (n_o[1:0])
      2'd1:    last_be_o = 4'b0001;
      2'd2:    last_be_o = 4'b0011;
      2'd3:    last_be_o = 4'b0111;
      default: last_be_o = 4'b1111;
    endcase
  end
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/dma_flow_chan.sv
module dma_flow_chan
  import dmac_pkg::*;
#(
  parameter int LEN_W   = 13,
  parameter int NUM_REQ = 2,
  parameter int CHAN_ID = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_i,
  input  logic [31:0]        ld_src_i,
  input  logic [31:0]        ld_tgt_i,
  input  logic [LEN_W-1:0]   ld_len_i,
  input  logic [1:0]         ld_bsz_i,
  input  logic               ld_inc_src_i,
  input  logic               ld_inc_tgt_i,
  input  logic               ld_flow_src_i,
  input  logic               ld_flow_tgt_i,
  input  logic               ld_irq_en_i,
  input  logic [NUM_REQ-1:0] dreq_i,
  input  logic [NUM_REQ*4-1:0] map_i,
  input  logic               irq_clr_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               irq_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [31:0]        src_addr_o,
  output logic [31:0]        tgt_addr_o,
  output logic               rd_valid_o,
  output logic [31:0]        rd_addr_o,
  input  logic               rd_ready_i,
  input  logic [31:0]        rd_data_i,
  output logic               wr_valid_o,
  output logic [31:0]        wr_addr_o,
  output logic [31:0]        wr_data_o,
  output logic [3:0]         wr_be_o,
  input  logic               wr_ready_i
);
  dma_state_e         state_q;
  dma_cmd_t           cmd_q;
  logic [ADDR_W-1:0]  src_q, tgt_q;
  logic [LEN_W-1:0]   len_q;
  logic [BEAT_W-1:0]  beat_q;
  logic               err_q, irq_q;

  logic               req_hit;
  logic [LEN_W-1:0]   burst_n;
  logic [BEAT_W-1:0]  beats;
  logic [BE_W-1:0]    last_be;
  logic               last_beat;
  logic [LEN_W-1:0]   len_next;
  logic [ADDR_W-1:0]  beat_off;
  logic               rd_fire, wr_fire, done_fire;

  dma_req_map #(.NUM_REQ(NUM_REQ), .CHAN_W(4), .CHAN_ID(CHAN_ID)) u_map (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq_i), .map_i(map_i), .hit_o(req_hit)
  );

  dma_burst_calc #(.LEN_W(LEN_W)) u_calc (
    .len_i(len_q), .bsz_i(cmd_q.bsz), .n_o(burst_n), .beats_o(beats), .last_be_o(last_be)
  );

  dma_stage_buf #(.DEPTH(BUF_WORDS), .W(DATA_W)) u_buf (
    .clk(clk), .wr_en_i(rd_fire), .wr_idx_i(beat_q[IDX_W-1:0]), .wr_data_i(rd_data_i),
    .rd_idx_i(beat_q[IDX_W-1:0]), .rd_data_o(wr_data_o)
  );

  assign last_beat = (beat_q + BEAT_W'(1)) == beats;
  assign len_next  = len_q - burst_n;
  assign beat_off  = ADDR_W'({beat_q, 2'b00});
  assign rd_fire   = rd_valid_o && rd_ready_i;
  assign wr_fire   = wr_valid_o && wr_ready_i;
  assign done_fire = wr_fire && last_beat && (len_next == '0);

  assign rd_valid_o = (state_q == ST_READ);
  assign wr_valid_o = (state_q == ST_WRITE);
  assign rd_addr_o  = src_q + (cmd_q.inc_src ? beat_off : '0);
  assign wr_addr_o  = tgt_q + (cmd_q.inc_tgt ? beat_off : '0);
  assign wr_be_o    = last_beat ? last_be : 4'hF;

  assign busy_o     = (state_q != ST_IDLE);
  assign err_o      = err_q;
  assign irq_o      = irq_q;
  assign len_o      = len_q;
  assign src_addr_o = src_q;
  assign tgt_addr_o = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      src_q   <= '0;
      tgt_q   <= '0;
      len_q   <= '0;
      beat_q  <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= (irq_q && !irq_clr_i) || (done_fire && cmd_q.irq_en);
      unique case (state_q)
        ST_IDLE: if (ld_i) begin
          if (ld_bsz_i == 2'd0) begin
            err_q <= 1'b1;
          end else begin
            err_q   <= 1'b0;
            src_q   <= ld_src_i;
            tgt_q   <= ld_tgt_i;
            len_q   <= ld_len_i;
            beat_q  <= '0;
            cmd_q   <= '{bsz: ld_bsz_i, inc_src: ld_inc_src_i, inc_tgt: ld_inc_tgt_i,
                         flow_src: ld_flow_src_i, flow_tgt: ld_flow_tgt_i, irq_en: ld_irq_en_i};
            if (ld_len_i != '0) state_q <= ld_flow_src_i ? ST_WAIT_SRC : ST_READ;
          end
        end
        ST_WAIT_SRC: if (req_hit) state_q <= ST_READ;
        ST_READ: if (rd_ready_i) begin
          if (last_beat) begin
            beat_q  <= '0;
            state_q <= cmd_q.flow_tgt ? ST_WAIT_TGT : ST_WRITE;
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        ST_WAIT_TGT: if (req_hit) state_q <= ST_WRITE;
        ST_WRITE: if (wr_ready_i) begin
          if (last_beat) begin
            beat_q <= '0;
            len_q  <= len_next;
            if (cmd_q.inc_src) src_q <= src_q + ADDR_W'(burst_n);
            if (cmd_q.inc_tgt) tgt_q <= tgt_q + ADDR_W'(burst_n);
            if (len_next == '0)        state_q <= ST_IDLE;
            else if (cmd_q.flow_src)   state_q <= ST_WAIT_SRC;
            else                       state_q <= ST_READ;
          end else begin
            beat_q <= beat_q + BEAT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Stream hold rules
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));
  assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
                                  && $stable(wr_data_o) && $stable(wr_be_o));
  // Word index stays inside the current burst
  assert_beat_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o || wr_valid_o) |-> beat_q < beats);
  // Remaining length never grows while running
  assert_len_mono_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> len_o <= $past(len_o));
  // No read while the source side is still waiting
  assert_wait_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_SRC) && !req_hit |=> !rd_valid_o);
  // Interrupt rises only as the channel finishes
  assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $fell(busy_o));
  // Error state never moves data
  assert_err_no_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !rd_valid_o && !wr_valid_o);
endmodule

// File: tb/test_dma_flow_chan.sv
`timescale 1ns/1ps
module test_dma_flow_chan;
  localparam int LEN_W = 13;
  localparam int CH    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_i = 1'b0;
  logic [31:0] ld_src_i = '0, ld_tgt_i = '0;
  logic [LEN_W-1:0] ld_len_i = '0;
  logic [1:0] ld_bsz_i = '0;
  logic ld_inc_src_i = 0, ld_inc_tgt_i = 0, ld_flow_src_i = 0, ld_flow_tgt_i = 0, ld_irq_en_i = 0;
  logic [1:0] dreq_i = '0;
  logic [7:0] map_i = {4'd6, 4'd5};
  logic irq_clr_i = 1'b0;
  logic busy_o, err_o, irq_o;
  logic [LEN_W-1:0] len_o;
  logic [31:0] src_addr_o, tgt_addr_o;
  logic rd_valid_o, rd_ready_i, wr_valid_o, wr_ready_i;
  logic [31:0] rd_addr_o, rd_data_i, wr_addr_o, wr_data_o;
  logic [3:0] wr_be_o;

  int n_chk = 0, n_fail = 0, cyc = 0, wcnt = 0, rcnt = 0;
  bit bp = 0;
  logic [31:0] log_addr [256];
  logic [31:0] log_data [256];
  logic [3:0]  log_be   [256];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction
  assign rd_data_i = mem_word(rd_addr_o);

  dma_flow_chan #(.LEN_W(LEN_W), .NUM_REQ(2), .CHAN_ID(CH)) i_dma_flow_chan (.*);

  always @(negedge clk) begin
    cyc = cyc + 1;
    rd_ready_i = !bp || (cyc % 3 != 0);
    wr_ready_i = !bp || (cyc % 2 == 0);
  end

  always @(posedge clk) begin
    if (rst_n && rd_valid_o && rd_ready_i) rcnt = rcnt + 1;
    if (rst_n && wr_valid_o && wr_ready_i) begin
      log_addr[wcnt % 256] = wr_addr_o;
      log_data[wcnt % 256] = wr_data_o;
      log_be[wcnt % 256]   = wr_be_o;
      wcnt = wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] t, input int len, input int bsz,
                      input bit is, input bit it, input bit fs, input bit ft, input bit ie);
    ld_src_i = s; ld_tgt_i = t; ld_len_i = LEN_W'(len); ld_bsz_i = 2'(bsz);
    ld_inc_src_i = is; ld_inc_tgt_i = it; ld_flow_src_i = fs; ld_flow_tgt_i = ft; ld_irq_en_i = ie;
    ld_i = 1'b1;
    @(negedge clk);
    ld_i = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy_o && guard < 3000) begin @(negedge clk); guard++; end
    chk(!busy_o, "R4 channel returns to idle", busy_o, 0);
  endtask

  task automatic run_xfer(input logic [31:0] s0, input logic [31:0] t0, input int len, input int bsz,
                          input bit is, input bit it, input bit fs, input bit ft, input bit ie,
                          input bit poke);
    int wbase = wcnt;
    int rem = len, k = 0, size = 4 << bsz;
    logic [31:0] s = s0, t = t0;
    dreq_i = (fs || ft) ? 2'b01 : 2'b00;
    load(s0, t0, len, bsz, is, it, fs, ft, ie);
    chk(busy_o == 1'b1, "R2 busy after load", busy_o, 1);
    chk(err_o == 1'b0, "R11 valid load clears error", err_o, 0);
    if (poke) begin
      cycles(2);
      load(32'hDEAD0000, 32'hBEEF0000, 99, 1, 1, 1, 0, 0, 0);
    end
    wait_idle();
    dreq_i = 2'b00;
    while (rem > 0) begin
      int n = (rem < size) ? rem : size;
      int beats = (n + 3) / 4;
      for (int b = 0; b < beats; b++) begin
        int idx = (wbase + k) % 256;
        logic [31:0] ea = t + (it ? 32'(4 * b) : 32'd0);
        logic [31:0] ed = mem_word(s + (is ? 32'(4 * b) : 32'd0));
        logic [3:0]  eb = (b == beats - 1 && (n % 4) != 0) ? 4'((1 << (n % 4)) - 1) : 4'hF;
        if (k < wcnt - wbase) begin
          chk(log_addr[idx] == ea, "R5 write address", log_addr[idx], ea);
          chk(log_data[idx] == ed, "R3 write data", log_data[idx], ed);
          chk(log_be[idx] == eb, "R6 byte enables", {28'd0, log_be[idx]}, {28'd0, eb});
        end
        k++;
      end
      if (is) s = s + 32'(n);
      if (it) t = t + 32'(n);
      rem = rem - n;
    end
    chk(wcnt - wbase == k, "R3 write word count", wcnt - wbase, k);
    chk(len_o == 0, "R4 final length", len_o, 0);
    chk(src_addr_o == s, "R5 final source", src_addr_o, s);
    chk(tgt_addr_o == t, "R5 final target", tgt_addr_o, t);
    chk(irq_o == ie, "R10 completion interrupt", irq_o, ie);
    cycles(3);
    chk(irq_o == ie, "R10 interrupt sticky", irq_o, ie);
    irq_clr_i = 1'b1; cycles(1); irq_clr_i = 1'b0;
    chk(irq_o == 1'b0, "R10 interrupt cleared", irq_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int rb, wb;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk(!busy_o && !err_o && !irq_o, "R1 reset flags", {busy_o, err_o, irq_o}, 0);
    chk(!rd_valid_o && !wr_valid_o && len_o == 0, "R1 reset ports idle", {rd_valid_o, wr_valid_o}, 0);

    // R9 requests while idle are ignored
    dreq_i = 2'b11; cycles(4); dreq_i = 2'b00; cycles(3);
    rb = rcnt;
    load(32'h100, 32'h200, 8, 1, 1, 1, 1, 0, 0);
    cycles(10);
    chk(rcnt == rb, "R9 idle requests not kept", rcnt - rb, 0);
    chk(busy_o == 1'b1, "R7 waiting for request", busy_o, 1);
    // R9 wrong-channel line does not release
    dreq_i = 2'b10; cycles(10); dreq_i = 2'b00; cycles(2);
    chk(rcnt == rb, "R9 unmapped line ignored", rcnt - rb, 0);
    dreq_i = 2'b01; wait_idle(); dreq_i = 2'b00; cycles(2);

    // R7 one pulse releases exactly one burst
    rb = rcnt; wb = wcnt;
    load(32'h400, 32'h800, 20, 1, 1, 1, 1, 0, 0);
    cycles(8);
    chk(rcnt == rb, "R7 no read before request", rcnt - rb, 0);
    dreq_i = 2'b01; cycles(1); dreq_i = 2'b00;
    cycles(15);
    chk(len_o == 12, "R4 length after one burst", len_o, 12);
    chk(rcnt - rb == 2 && wcnt - wb == 2, "R7 single burst moved", rcnt - rb, 2);
    cycles(10);
    chk(rcnt - rb == 2, "R7 waits again next burst", rcnt - rb, 2);
    dreq_i = 2'b01; wait_idle(); dreq_i = 2'b00;
    chk(rcnt - rb == 5 && len_o == 0, "R4 flow transfer complete", rcnt - rb, 5);

    // R8 target side waits after reads
    rb = rcnt; wb = wcnt;
    load(32'h1000, 32'hF000, 8, 1, 1, 0, 0, 1, 0);
    cycles(15);
    chk(rcnt - rb == 2, "R8 reads complete", rcnt - rb, 2);
    chk(wcnt - wb == 0 && !wr_valid_o, "R8 no write before request", wcnt - wb, 0);
    dreq_i = 2'b01; cycles(1); dreq_i = 2'b00;
    cycles(10);
    chk(wcnt - wb == 2 && !busy_o, "R8 writes after request", wcnt - wb, 2);

    // R11 invalid burst code
    rb = rcnt;
    load(32'h100, 32'h200, 8, 0, 1, 1, 0, 0, 0);
    chk(err_o == 1'b1, "R11 error set", err_o, 1);
    chk(busy_o == 1'b0, "R11 not started", busy_o, 0);
    cycles(5);
    chk(rcnt == rb, "R11 no reads", rcnt - rb, 0);

    // R3/R4/R5/R6 sweep of lengths and burst sizes
    for (int bsz = 1; bsz <= 3; bsz++)
      for (int len = 1; len <= 36; len++) begin
        bp = len[1];
        run_xfer(32'h0001_0000 + 32'(len * 256), 32'h8000_0000 + 32'(bsz * 4096),
                 len, bsz, 1, 1, 0, 0, len[0], 0);
      end

    // R5 increment combinations, with flow control and back-pressure
    for (int m = 0; m < 4; m++)
      for (int bsz = 1; bsz <= 2; bsz++) begin
        bp = m[0];
        run_xfer(32'h2000, 32'h3000, 21, bsz, m[0], m[1], bsz == 2, m == 3, 1, 0);
      end

    // R2 load while busy is ignored
    bp = 1;
    run_xfer(32'h5000, 32'h6000, 24, 1, 1, 1, 0, 0, 0, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule